// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte offered on a valid/ready handshake is parked in a one-entry holding register. When the shift path is idle and transmission is not halted, the byte moves into the shifter and goes out as a start bit, five to eight data bits, an optional parity bit and a programmable stop period. All bit timing comes from an external oversampling tick; every bit lasts a fixed number of ticks (16 by default).

The frame format is selected by static control inputs: a character length code, parity enable, even/odd choice, a stick-parity option, and a stop-width choice. The stop width can come either from the shared line-control bit or, in split mode, from a transmit-only bit. The format inputs are sampled at the moment a character is loaded, so a change while a frame is on the line applies to the next character. A break input pulls the line low without disturbing frame timing, and a halt input keeps new characters from starting.

Top module: `sertx_frame_tx`

## Requirements
- R1: The length code `len_code_i` values 0, 1, 2, 3 send 5, 6, 7, 8 data bits, least significant bit first, directly after the start bit.
- R2: With `par_en_i` = 1 and `par_stick_i` = 0, one parity bit follows the data: with `par_even_i` = 1 it makes the count of ones over data plus parity even, with `par_even_i` = 0 it makes that count odd. With `par_en_i` = 0 no parity bit is sent.
- R3: With `par_en_i` = 1 and `par_stick_i` = 1, the parity bit is the constant 0 when `par_even_i` = 1 and the constant 1 when `par_even_i` = 0.
- R4: The stop period is high and lasts 16 ticks when the selected stop bit is 0; when it is 1 it lasts 24 ticks for length code 0 and 32 ticks for any other length code.
- R5: With `stop_split_i` = 1 the selected stop bit is `stop_tx_i`; with `stop_split_i` = 0 it is `stop_sel_i`.
- R6: The idle line is high, the start bit is low, and each start, data and parity bit lasts 16 ticks; `busy_o` is high exactly while a frame is being timed.
- R7: While `brk_i` is 1, `txd_o` is 0, whether idle or mid-frame, and frame timing continues unchanged.
- R8: While `halt_i` is 1 no new character starts; a halt raised during a frame lets that frame complete with its full length.
- R9: After reset `txd_o` = 1, `busy_o` = 0, `ready_o` = 1 and `empty_o` = 1; `empty_o` is 1 only when the holding register and the shifter are both empty.
- R10: The holding register takes one byte on `valid_i` and `ready_o` both high; `ready_o` stays low until that byte has moved into the shifter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling tick, one-cycle pulse |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte on `data_i` is offered |
| ready_o | output | 1 | Holding register can take a byte |
| len_code_i | input | 2 | Character length code (5 + code bits) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick parity select |
| stop_sel_i | input | 1 | Shared stop-width bit |
| stop_split_i | input | 1 | Use transmit-only stop-width bit |
| stop_tx_i | input | 1 | Transmit-only stop-width bit |
| brk_i | input | 1 | Force the line low |
| halt_i | input | 1 | Hold off new characters |
| txd_o | output | 1 | Serial output line |
| busy_o | output | 1 | Frame in progress |
| empty_o | output | 1 | Holding register and shifter both empty |

## Verification
The properties take for granted that reset is asserted before the first clock edge and that `brk_i`, `halt_i` and `valid_i` are synchronous to `clk`; the line-level properties rely on break being the only thing that can pull an idle line low. The stimulus changes every input shortly after a rising edge, pulses the tick for one cycle out of every four, and keeps the format inputs steady while a frame is expected to be captured, so each frame seen on the line reflects a single known configuration.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

endpackage

// File: rtl/sertx_fmt_decode.sv
// Turns the line-control inputs and a byte into the per-frame parameters:
// data bit count, parity presence and value, and stop length in ticks.
module sertx_fmt_decode #(
    parameter int OS = 16,
    parameter int DW = 8,
    localparam int CW = $clog2(2 * OS + 1),
    localparam int NW = $clog2(DW + 1)
) (
    input  logic [1:0]    len_code_i,
    input  logic          par_en_i,
    input  logic          par_even_i,
    input  logic          par_stick_i,
    input  logic          stop_sel_i,
    input  logic          stop_split_i,
    input  logic          stop_tx_i,
    input  logic [DW-1:0] data_i,
    output logic [NW-1:0] nbits_o,
    output logic          par_on_o,
    output logic          par_bit_o,
    output logic [CW-1:0] stop_ticks_o
);
    logic [DW-1:0] used;
    logic          ones_odd;
    logic          long_stop;

    assign nbits_o = NW'(5) + NW'(len_code_i);

    // keep only the bits that are actually sent
    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign used[i] = data_i[i] & (NW'(i) < nbits_o);
    end

    always_comb begin
        ones_odd  = ^used;
        par_on_o  = par_en_i;
        if (par_stick_i) begin
            par_bit_o = ~par_even_i;
        end else if (par_even_i) begin
            par_bit_o = ones_odd;
        end else begin
            par_bit_o = ~ones_odd;
        end

        long_stop = stop_split_i ? stop_tx_i : stop_sel_i;
        if (!long_stop) begin
            stop_ticks_o = CW'(OS);
        end else if (len_code_i == 2'd0) begin
            stop_ticks_o = CW'(OS + OS / 2);
        end else begin
            stop_ticks_o = CW'(2 * OS);
        end
    end

endmodule

// File: rtl/sertx_bit_timer.sv
// Counts oversampling ticks within one bit period and flags the last one.
module sertx_bit_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_end;

    always_comb begin
        at_end   = (cnt_q == limit_i - CW'(1));
        expire_o = tick_i && !restart_i && at_end;
        cnt_d    = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = at_end ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sertx_frame_tx.sv
module sertx_frame_tx #(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [DW-1:0] data_i,
    input  logic          valid_i,
    output logic          ready_o,
    input  logic [1:0]    len_code_i,
    input  logic          par_en_i,
    input  logic          par_even_i,
    input  logic          par_stick_i,
    input  logic          stop_sel_i,
    input  logic          stop_split_i,
    input  logic          stop_tx_i,
    input  logic          brk_i,
    input  logic          halt_i,
    output logic          txd_o,
    output logic          busy_o,
    output logic          empty_o
);
    import sertx_pkg::*;

    localparam int CW = $clog2(2 * OS + 1);
    localparam int NW = $clog2(DW + 1);

    typedef struct packed {
        tx_state_e     st;
        logic          hold_full;
        logic [DW-1:0] hold;
        logic [DW-1:0] shift;
        logic [NW-1:0] left;
        logic          par_on;
        logic          par_bit;
        logic [CW-1:0] stop_ticks;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    logic [NW-1:0] dec_nbits;
    logic          dec_par_on;
    logic          dec_par_bit;
    logic [CW-1:0] dec_stop;
    logic [CW-1:0] bit_limit;
    logic          bit_done;
    logic          timer_rst;

    sertx_fmt_decode #(.OS(OS), .DW(DW)) u_fmt (
        .len_code_i   (len_code_i),
        .par_en_i     (par_en_i),
        .par_even_i   (par_even_i),
        .par_stick_i  (par_stick_i),
        .stop_sel_i   (stop_sel_i),
        .stop_split_i (stop_split_i),
        .stop_tx_i    (stop_tx_i),
        .data_i       (r_q.hold),
        .nbits_o      (dec_nbits),
        .par_on_o     (dec_par_on),
        .par_bit_o    (dec_par_bit),
        .stop_ticks_o (dec_stop)
    );

    assign timer_rst = (r_q.st == ST_IDLE);
    assign bit_limit = (r_q.st == ST_STOP) ? r_q.stop_ticks : CW'(OS);

    sertx_bit_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (timer_rst),
        .tick_i    (tick_i),
        .limit_i   (bit_limit),
        .expire_o  (bit_done)
    );

    always_comb begin
        r_d = r_q;

        if (valid_i && !r_q.hold_full) begin
            r_d.hold_full = 1'b1;
            r_d.hold      = data_i;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.hold_full && !halt_i) begin
                    r_d.st         = ST_START;
                    r_d.hold_full  = 1'b0;
                    r_d.shift      = r_q.hold;
                    r_d.left       = dec_nbits;
                    r_d.par_on     = dec_par_on;
                    r_d.par_bit    = dec_par_bit;
                    r_d.stop_ticks = dec_stop;
                end
            end
            ST_START: begin
                if (bit_done) begin
                    r_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_done) begin
                    r_d.shift = r_q.shift >> 1;
                    r_d.left  = r_q.left - NW'(1);
                    if (r_q.left == NW'(1)) begin
                        r_d.st = r_q.par_on ? ST_PAR : ST_STOP;
                    end
                end
            end
            ST_PAR: begin
                if (bit_done) begin
                    r_d.st = ST_STOP;
                end
            end
            ST_STOP: begin
                if (bit_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (brk_i) begin
            txd_o = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_START: txd_o = 1'b0;
                ST_DATA:  txd_o = r_q.shift[0];
                ST_PAR:   txd_o = r_q.par_bit;
                default:  txd_o = 1'b1;
            endcase
        end
    end

    assign ready_o = !r_q.hold_full;
    assign busy_o  = (r_q.st != ST_IDLE);
    assign empty_o = !r_q.hold_full && (r_q.st == ST_IDLE);

endmodule

// File: rtl/sertx_frame_tx_chk.sv
module sertx_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic valid_i,
    input logic ready_o,
    input logic brk_i,
    input logic halt_i,
    input logic txd_o,
    input logic busy_o,
    input logic empty_o
);
    // R7: break owns the line
    p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |-> !txd_o);

    // R6: idle line sits high unless broken
    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !brk_i) |-> txd_o);

    // R6: a frame opens with a low start bit
    p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && !brk_i) |-> !txd_o);

    // R8: halted idle transmitter stays idle
    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && halt_i) |=> !busy_o);

    // R9: empty implies nothing held and nothing shifting
    p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (!busy_o && ready_o));

    // R10: an accepted byte closes the holding register
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> !ready_o);

endmodule

bind sertx_frame_tx sertx_frame_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .brk_i   (brk_i),
    .halt_i  (halt_i),
    .txd_o   (txd_o),
    .busy_o  (busy_o),
    .empty_o (empty_o)
);

// File: tb/sertx_frame_tx_tb.sv
`timescale 1ns/1ps
module sertx_frame_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       valid_i = 1'b0;
    logic       ready_o;
    logic [1:0] len_code_i = 2'd3;
    logic       par_en_i = 1'b0;
    logic       par_even_i = 1'b0;
    logic       par_stick_i = 1'b0;
    logic       stop_sel_i = 1'b0;
    logic       stop_split_i = 1'b0;
    logic       stop_tx_i = 1'b0;
    logic       brk_i = 1'b0;
    logic       halt_i = 1'b0;
    logic       txd_o;
    logic       busy_o;
    logic       empty_o;

    int total = 0;
    int bad   = 0;

    logic cap [256];
    int   cap_n = 0;
    logic expv [256];
    int   exp_n = 0;

    always #2 clk = ~clk;

    sertx_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .data_i(data_i),
        .valid_i(valid_i), .ready_o(ready_o), .len_code_i(len_code_i),
        .par_en_i(par_en_i), .par_even_i(par_even_i), .par_stick_i(par_stick_i),
        .stop_sel_i(stop_sel_i), .stop_split_i(stop_split_i), .stop_tx_i(stop_tx_i),
        .brk_i(brk_i), .halt_i(halt_i), .txd_o(txd_o), .busy_o(busy_o),
        .empty_o(empty_o)
    );

    // tick: one cycle high out of four, changed just after a rising edge
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick_i = 1'b1;
            @(posedge clk);
            #1 tick_i = 1'b0;
        end
    end

    // line capture: one sample per tick while a frame is timed
    initial begin
        forever begin
            @(negedge clk);
            if (tick_i && busy_o && cap_n < 256) begin
                cap[cap_n] = txd_o;
                cap_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expd);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expd);
        end
    endtask

    task automatic put(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            expv[exp_n] = v;
            exp_n++;
        end
    endtask

    // expected tick-by-tick line for one frame, from the requirements
    task automatic build_exp(input logic [7:0] d, input int len, input bit pen,
                             input bit even, input bit stick, input bit longstop);
        int   nb;
        logic ones;
        logic pb;
        nb   = 5 + len;
        exp_n = 0;
        ones = 1'b0;
        put(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            put(d[i], 16);
            ones = ones ^ d[i];
        end
        if (pen) begin
            if (stick)     pb = ~even;
            else if (even) pb = ones;
            else           pb = ~ones;
            put(pb, 16);
        end
        if (!longstop)     put(1'b1, 16);
        else if (len == 0) put(1'b1, 24);
        else               put(1'b1, 32);
    endtask

    task automatic offer(input logic [7:0] d);
        @(negedge clk);
        chk(ready_o == 1'b1, "R10 ready before offer", int'(ready_o), 1);
        data_i  = d;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!busy_o) @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        int first;
        first = -1;
        chk(cap_n == exp_n, {tag, " frame ticks"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            if (first < 0 && cap[i] !== expv[i]) first = i;
        end
        if (first < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, {tag, " line bit"}, int'(cap[first]), int'(expv[first]));
    endtask

    task automatic run_frame(input string tag, input logic [7:0] d, input int len,
                             input bit pen, input bit even, input bit stick,
                             input bit ssel, input bit split, input bit stx);
        bit longstop;
        @(negedge clk);
        len_code_i   = 2'(len);
        par_en_i     = pen;
        par_even_i   = even;
        par_stick_i  = stick;
        stop_sel_i   = ssel;
        stop_split_i = split;
        stop_tx_i    = stx;
        longstop     = split ? stx : ssel;
        build_exp(d, len, pen, even, stick, longstop);
        cap_n = 0;
        offer(d);
        wait_done();
        compare(tag);
        chk(empty_o == 1'b1, {tag, " R9 empty after frame"}, int'(empty_o), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(txd_o == 1'b1, "R9 reset txd", int'(txd_o), 1);
        chk(busy_o == 1'b0, "R9 reset busy", int'(busy_o), 0);
        chk(ready_o == 1'b1, "R9 reset ready", int'(ready_o), 1);
        chk(empty_o == 1'b1, "R9 reset empty", int'(empty_o), 1);
    endtask

    task automatic t_lengths();
        run_frame("R1 R6 8N1", 8'hA5, 3, 0, 0, 0, 0, 0, 0);
        run_frame("R1 6-bit", 8'hF6, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_parity();
        run_frame("R2 R4 5-bit even 1.5 stop", 8'h1B, 0, 1, 1, 0, 1, 0, 0);
        run_frame("R2 R4 7-bit odd 2 stop", 8'h55, 2, 1, 0, 0, 1, 0, 0);
        run_frame("R2 8-bit even", 8'h03, 3, 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_stick();
        run_frame("R3 stick low", 8'h01, 3, 1, 1, 1, 0, 0, 0);
        run_frame("R3 stick high", 8'h01, 3, 1, 0, 1, 0, 0, 0);
    endtask

    task automatic t_split();
        run_frame("R5 split short", 8'h3C, 3, 0, 0, 0, 1, 1, 0);
        run_frame("R5 split long", 8'h3C, 3, 0, 0, 0, 0, 1, 1);
        run_frame("R5 R4 split 1.5", 8'h0A, 0, 0, 0, 0, 0, 1, 1);
    endtask

    task automatic t_break();
        @(negedge clk);
        brk_i = 1'b1;
        @(negedge clk);
        chk(txd_o == 1'b0, "R7 break idle", int'(txd_o), 0);
        build_exp(8'hFF, 3, 0, 0, 0, 0);
        for (int i = 0; i < exp_n; i++) expv[i] = 1'b0;
        len_code_i = 2'd3; par_en_i = 0; stop_sel_i = 0; stop_split_i = 0;
        cap_n = 0;
        offer(8'hFF);
        wait_done();
        compare("R7 break mid-frame");
        brk_i = 1'b0;
        @(negedge clk);
        chk(txd_o == 1'b1, "R7 release", int'(txd_o), 1);
    endtask

    task automatic t_halt();
        bit moved;
        moved = 1'b0;
        @(negedge clk);
        halt_i = 1'b1;
        len_code_i = 2'd3; par_en_i = 0; stop_sel_i = 0; stop_split_i = 0;
        offer(8'h81);
        repeat (200) begin
            @(negedge clk);
            if (busy_o) moved = 1'b1;
        end
        chk(!moved, "R8 halt blocks start", int'(moved), 0);
        chk(ready_o == 1'b0, "R10 held byte keeps ready low", int'(ready_o), 0);
        chk(empty_o == 1'b0, "R9 held byte not empty", int'(empty_o), 0);
        build_exp(8'h81, 3, 0, 0, 0, 0);
        cap_n = 0;
        halt_i = 1'b0;
        while (!busy_o) @(negedge clk);
        repeat (40) @(negedge clk);
        halt_i = 1'b1;
        while (busy_o) @(negedge clk);
        compare("R8 halt mid-frame finishes");
        halt_i = 1'b0;
    endtask

    task automatic t_handshake();
        len_code_i = 2'd3; par_en_i = 0; stop_sel_i = 0; stop_split_i = 0;
        offer(8'h11);
        while (!busy_o) @(negedge clk);
        offer(8'h22);
        chk(ready_o == 1'b0, "R10 second byte held", int'(ready_o), 0);
        chk(empty_o == 1'b0, "R9 not empty with byte held", int'(empty_o), 0);
        while (!empty_o) @(negedge clk);
        chk(ready_o == 1'b1, "R10 ready after drain", int'(ready_o), 1);
        chk(busy_o == 1'b0, "R9 idle after drain", int'(busy_o), 0);
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_parity();
        t_stick();
        t_split();
        t_break();
        t_halt();
        t_handshake();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule